// File: doc/BRIEF.md
# Opcode Fetch Patch Redirector

This unit sits beside the instruction fetch path of an 8-bit processor with a 16-bit address space and lets a few instructions held in read-only program memory be replaced after manufacture. Software loads up to two 16-bit trap addresses and a control byte through a byte-wide register port. Each trap address is written as a high byte and a low byte. When the processor performs an opcode fetch whose address equals an armed trap, the unit raises a redirect strobe. In the same cycle it presents a fixed patch vector in place of the fetch address. The patch code runs from that vector and goes back to the main program with an ordinary three-byte absolute jump.

Each trap has its own vector. A single control bit chooses whether both vectors sit in the low RAM copy or in the high ROM copy. The compare is combinational against the registered settings. A register write therefore affects the first fetch presented after the clock edge that stores it. Operand fetches and data accesses pass straight through and are never redirected.

Top module: `patch_redirect`

## Requirements
- R1: After reset both trap addresses read 0x0000 and the control byte reads 0x00, so no fetch is redirected.
- R2: Trap 0 takes its high byte at 0x0FF8 and its low byte at 0x0FF9. Trap 1 takes its high byte at 0x0FFA and its low byte at 0x0FFB. Each register reads back the last byte written to it, through `reg_rdata` for the address on `reg_addr`.
- R3: The control byte is at 0x0FFC. Bit 0 arms trap 0, bit 1 arms trap 1, and bit 2 selects the vector region. Bits 7..3 always read 0, whatever value was written to them.
- R4: With bit 2 = 0, an opcode fetch at an armed trap 0 address gives `redir_hit` = 1 and `out_addr` = 0x0100.
- R5: With bit 2 = 0, an opcode fetch at an armed trap 1 address gives `redir_hit` = 1 and `out_addr` = 0x0120.
- R6: With bit 2 = 1, the same hits give 0xF100 for trap 0 and 0xF120 for trap 1.
- R7: A trap whose arm bit is 0 never redirects, even when the fetch address equals its stored address.
- R8: When `fetch_opcode` = 0, `redir_hit` is 0 and `out_addr` equals `fetch_addr`, whatever the address.
- R9: If both traps are armed and hold the same address, a fetch there takes trap 0's vector.
- R10: When no armed trap matches, `redir_hit` = 0 and `out_addr` equals `fetch_addr`.
- R11: `redir_hit` and `out_addr` depend combinationally on the fetch inputs. A fetch in the same cycle as a register write sees the old settings. The first fetch after the storing edge sees the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 16 | Register port address |
| reg_wr | input | 1 | Write strobe; the byte is stored at the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`; 0 for addresses outside the map |
| fetch_addr | input | 16 | Address of the current processor access |
| fetch_opcode | input | 1 | High when the access is an opcode fetch |
| redir_hit | output | 1 | High when the access is redirected |
| out_addr | output | 16 | Patch vector on a redirect, otherwise `fetch_addr` |

## Verification
A register write and an opcode fetch can land in the same cycle. This matters most when the write arms or moves the trap that the fetch is aimed at. The bench drives a control write and a matching fetch together and checks just before the edge that the old setting still holds. It then checks on the next fetch that the new setting has taken effect. A second overlap is both traps matching one fetch. The bench sweeps every control byte against a window of fetch addresses, with and without the fetch strobe, including a pass where both traps hold the same address and trap 0 must win.

// File: rtl/patch_pkg.sv
package patch_pkg;
  // register port byte width
  localparam int BYTE_W = 8;
  // a trap address is split into this many bytes
  localparam int ADDR_BYTES = 2;
endpackage

// File: rtl/patch_cmp.sv
module patch_cmp #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_opcode,
  input  logic [ADDR_W-1:0] trap_addr,
  input  logic              armed,
  output logic              hit
);
  // qualify the equality with both the arm bit and the opcode strobe
  assign hit = fetch_opcode && armed && (fetch_addr == trap_addr);
endmodule

// File: rtl/patch_regs.sv
module patch_regs
  import patch_pkg::*;
#(
  parameter int              N_TRAP   = 2,
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h0FF8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic                           reg_wr,
  input  logic [BYTE_W-1:0]              reg_wdata,
  output logic [BYTE_W-1:0]              reg_rdata,
  output logic [N_TRAP-1:0][ADDR_W-1:0]  trap_addr,
  output logic [N_TRAP-1:0]              armed,
  output logic                           rom_sel
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = REG_BASE + ADDR_W'(ADDR_BYTES * N_TRAP);

  logic [N_TRAP-1:0][ADDR_W-1:0] addr_q;
  logic [N_TRAP-1:0]             arm_q;
  logic                          sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      arm_q  <= '0;
      sel_q  <= 1'b0;
    end else if (reg_wr) begin
      for (int i = 0; i < N_TRAP; i++) begin
        if (reg_addr == REG_BASE + ADDR_W'(ADDR_BYTES * i))
          addr_q[i][ADDR_W-1:BYTE_W] <= reg_wdata;
        if (reg_addr == REG_BASE + ADDR_W'(ADDR_BYTES * i + 1))
          addr_q[i][BYTE_W-1:0] <= reg_wdata;
      end
      if (reg_addr == CTRL_ADDR) begin
        arm_q <= reg_wdata[N_TRAP-1:0];
        sel_q <= reg_wdata[N_TRAP];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < N_TRAP; i++) begin
      if (reg_addr == REG_BASE + ADDR_W'(ADDR_BYTES * i))
        reg_rdata = addr_q[i][ADDR_W-1:BYTE_W];
      if (reg_addr == REG_BASE + ADDR_W'(ADDR_BYTES * i + 1))
        reg_rdata = addr_q[i][BYTE_W-1:0];
    end
    if (reg_addr == CTRL_ADDR) begin
      reg_rdata[N_TRAP-1:0] = arm_q;
      reg_rdata[N_TRAP]     = sel_q;
    end
  end

  assign trap_addr = addr_q;
  assign armed     = arm_q;
  assign rom_sel   = sel_q;

  // leaving reset: every trap disarmed
  assert_reset_disarmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (arm_q == '0));

  // trap addresses change only after a write cycle
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr) |-> $stable(addr_q));

  // a control write lands on the next edge
  assert_ctrl_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_wr && reg_addr == CTRL_ADDR) |-> (arm_q == $past(reg_wdata[N_TRAP-1:0])));
endmodule

// File: rtl/patch_redirect.sv
module patch_redirect
  import patch_pkg::*;
#(
  parameter int                N_TRAP       = 2,
  parameter int                ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] REG_BASE     = 16'h0FF8,
  parameter logic [ADDR_W-1:0] VEC_RAM_BASE = 16'h0100,
  parameter logic [ADDR_W-1:0] VEC_ROM_BASE = 16'hF100,
  parameter logic [ADDR_W-1:0] VEC_STRIDE   = 16'h0020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [15:0]       fetch_addr,
  input  logic              fetch_opcode,
  output logic              redir_hit,
  output logic [15:0]       out_addr
);
  localparam int IDX_W = (N_TRAP > 1) ? $clog2(N_TRAP) : 1;

  logic [N_TRAP-1:0][ADDR_W-1:0] trap_addr;
  logic [N_TRAP-1:0]             armed;
  logic                          rom_sel;
  logic [N_TRAP-1:0]             hit_vec;
  logic [IDX_W-1:0]              win_idx;
  logic [ADDR_W-1:0]             vec_base;
  logic [ADDR_W-1:0]             vec_addr;

  patch_regs #(
    .N_TRAP   (N_TRAP),
    .ADDR_W   (ADDR_W),
    .REG_BASE (REG_BASE)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .trap_addr (trap_addr),
    .armed     (armed),
    .rom_sel   (rom_sel)
  );

  for (genvar g = 0; g < N_TRAP; g++) begin : g_cmp
    patch_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .fetch_addr   (fetch_addr),
      .fetch_opcode (fetch_opcode),
      .trap_addr    (trap_addr[g]),
      .armed        (armed[g]),
      .hit          (hit_vec[g])
    );
  end

  // lowest index wins: scan downward so the last assignment is the smallest hit
  always_comb begin
    win_idx = '0;
    for (int i = N_TRAP - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = IDX_W'(i);
    end
  end

  assign vec_base  = rom_sel ? VEC_ROM_BASE : VEC_RAM_BASE;
  assign vec_addr  = vec_base + ({{(ADDR_W-IDX_W){1'b0}}, win_idx} * VEC_STRIDE);
  assign redir_hit = |hit_vec;
  assign out_addr  = redir_hit ? vec_addr : fetch_addr;

  // a redirect only ever follows an opcode fetch
  assert_hit_needs_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_hit |-> fetch_opcode);

  // a redirect always lands on a vector slot of the selected region
  assert_vector_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redir_hit |-> (((out_addr - vec_base) % VEC_STRIDE) == '0));

  // trap 0 hit takes trap 0 vector regardless of the others
  assert_trap0_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vec[0] |-> (out_addr == vec_base));

  // no hit: address passes through
  assert_passthrough_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_hit |-> (out_addr == fetch_addr));
endmodule

// File: tb/patch_redirect_tb.sv
`timescale 1ns/1ps
module patch_redirect_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] fetch_addr = '0;
  logic        fetch_opcode = 1'b0;
  logic        redir_hit;
  logic [15:0] out_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench-side copy of the programmed settings
  logic [15:0] m_addr0 = '0, m_addr1 = '0;
  logic [7:0]  m_ctrl = '0;

  always #2.5 clk = ~clk;

  patch_redirect u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_addr(fetch_addr),
    .fetch_opcode(fetch_opcode), .redir_hit(redir_hit), .out_addr(out_addr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      16'h0FF8: m_addr0[15:8] = d;
      16'h0FF9: m_addr0[7:0]  = d;
      16'h0FFA: m_addr1[15:8] = d;
      16'h0FFB: m_addr1[7:0]  = d;
      16'h0FFC: m_ctrl = {5'b0, d[2:0]};
      default: ;
    endcase
  endtask

  task automatic rd_check(input logic [15:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a;
    #1;
    check(reg_rdata === exp, tag, {24'b0, reg_rdata}, {24'b0, exp});
  endtask

  // expected output from the requirements
  task automatic expect_out(input logic [15:0] fa, input bit op, output bit h, output logic [15:0] oa);
    logic [15:0] base;
    base = m_ctrl[2] ? 16'hF100 : 16'h0100;
    h = 1'b0; oa = fa;
    if (op && m_ctrl[0] && fa == m_addr0) begin h = 1'b1; oa = base; end
    else if (op && m_ctrl[1] && fa == m_addr1) begin h = 1'b1; oa = base + 16'h0020; end
  endtask

  task automatic fetch_check(input logic [15:0] fa, input bit op, input string tag);
    bit h; logic [15:0] oa;
    fetch_addr = fa; fetch_opcode = op;
    #1;
    expect_out(fa, op, h, oa);
    check(redir_hit === h && out_addr === oa, tag, {15'b0, redir_hit, out_addr}, {15'b0, h, oa});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd_check(16'h0FF8, 8'h00, "R1 a0 hi");
    rd_check(16'h0FF9, 8'h00, "R1 a0 lo");
    rd_check(16'h0FFA, 8'h00, "R1 a1 hi");
    rd_check(16'h0FFB, 8'h00, "R1 a1 lo");
    rd_check(16'h0FFC, 8'h00, "R1 ctrl");
    fetch_check(16'h0000, 1'b1, "R1 no redirect at 0000");

    // R2: register map and readback
    wr(16'h0FF8, 8'hC0); wr(16'h0FF9, 8'h10);
    wr(16'h0FFA, 8'hC0); wr(16'h0FFB, 8'h13);
    rd_check(16'h0FF8, 8'hC0, "R2 a0 hi");
    rd_check(16'h0FF9, 8'h10, "R2 a0 lo");
    rd_check(16'h0FFA, 8'hC0, "R2 a1 hi");
    rd_check(16'h0FFB, 8'h13, "R2 a1 lo");

    // R3: upper control bits read zero
    wr(16'h0FFC, 8'hFF);
    rd_check(16'h0FFC, 8'h07, "R3 ctrl upper bits");
    wr(16'h0FFC, 8'hA8);
    rd_check(16'h0FFC, 8'h00, "R3 ctrl upper only");

    // R4 R5 R6 R7 R8 R10: sweep every control setting over a window
    for (int c = 0; c < 8; c++) begin
      wr(16'h0FFC, 8'(c));
      for (int a = 16'hC000; a < 16'hC020; a++) begin
        for (int op = 0; op < 2; op++) begin
          @(negedge clk);
          fetch_check(16'(a), op[0], "R4 R5 R6 R7 R8 R10 sweep");
        end
      end
    end
    // explicit vector values
    wr(16'h0FFC, 8'h03);
    fetch_check(16'hC010, 1'b1, "R4 trap0 ram");
    check(out_addr === 16'h0100, "R4 vector 0100", {16'b0, out_addr}, 32'h0100);
    fetch_check(16'hC013, 1'b1, "R5 trap1 ram");
    check(out_addr === 16'h0120, "R5 vector 0120", {16'b0, out_addr}, 32'h0120);
    wr(16'h0FFC, 8'h07);
    fetch_check(16'hC010, 1'b1, "R6 trap0 rom");
    check(out_addr === 16'hF100, "R6 vector F100", {16'b0, out_addr}, 32'hF100);
    fetch_check(16'hC013, 1'b1, "R6 trap1 rom");
    check(out_addr === 16'hF120, "R6 vector F120", {16'b0, out_addr}, 32'hF120);
    wr(16'h0FFC, 8'h01);
    fetch_check(16'hC013, 1'b1, "R7 trap1 disarmed");
    check(redir_hit === 1'b0, "R7 no hit", {31'b0, redir_hit}, 32'h0);

    // R9: both traps on one address
    wr(16'h0FFB, 8'h10);
    for (int c = 0; c < 8; c++) begin
      wr(16'h0FFC, 8'(c));
      fetch_check(16'hC010, 1'b1, "R9 same address priority");
    end
    wr(16'h0FFC, 8'h03);
    check(out_addr === 16'h0100, "R9 trap0 wins", {16'b0, out_addr}, 32'h0100);

    // R11: write and fetch in the same cycle
    wr(16'h0FFC, 8'h00);
    @(negedge clk);
    reg_addr = 16'h0FFC; reg_wdata = 8'h01; reg_wr = 1'b1;
    fetch_addr = 16'hC010; fetch_opcode = 1'b1;
    #1;
    check(redir_hit === 1'b0 && out_addr === 16'hC010, "R11 old setting in write cycle",
          {15'b0, redir_hit, out_addr}, {15'b0, 1'b0, 16'hC010});
    @(negedge clk);
    reg_wr = 1'b0; m_ctrl = 8'h01;
    #1;
    check(redir_hit === 1'b1 && out_addr === 16'h0100, "R11 new setting next fetch",
          {15'b0, redir_hit, out_addr}, {15'b0, 1'b1, 16'h0100});
    // moving a trap address in the fetch cycle
    @(negedge clk);
    reg_addr = 16'h0FF9; reg_wdata = 8'h55; reg_wr = 1'b1;
    #1;
    check(redir_hit === 1'b1, "R11 old address in write cycle", {31'b0, redir_hit}, 32'h1);
    @(negedge clk);
    reg_wr = 1'b0; m_addr0[7:0] = 8'h55;
    #1;
    check(redir_hit === 1'b0, "R11 moved address next fetch", {31'b0, redir_hit}, 32'h0);
    fetch_check(16'hC055, 1'b1, "R11 new address hits");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule